// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI bus master that software drives through a small 32-bit register bus. Software loads words into a transmit FIFO through a data register. The shift engine sends each word on `sclk`/`mosi` and captures the word arriving on `miso` into a receive FIFO, which software drains through a second data register. The serial clock rate is fixed by the `HALF_CYC` parameter, which gives the number of system clocks per SCLK half period. It cannot be changed from software.

Software usually sets the transmit hold bit, preloads a burst into the transmit FIFO, picks a slave in the slave-select register and clears the hold bit. The engine then drains the FIFO without further help. When the last word has left and nothing more is queued, the block raises a one-cycle event for the interrupt logic. All four clock polarity/phase combinations are supported, in either bit order. An internal loopback feeds the serial output back into the receiver for self-test.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, control reads 0x100 (transmit hold set, all else clear), status reads 0x05, the slave-select register reads all ones, `ss_n` is all ones and `sclk` is low.
- R2: Register byte offsets (bits [1:0] ignored) are: control 0x60, status 0x64, transmit data 0x68, receive data 0x6C, slave select 0x70. Control bits are: 0 loopback, 1 enable, 2 master, 3 clock polarity, 4 clock phase, 5 TX flush, 6 RX flush, 7 manual select, 8 transmit hold, 9 LSB first. Bits 5 and 6 always read back as 0.
- R3: A word is shifted only while enable=1, master=1 and hold=0. While any of these is not met, a queued word produces no SCLK edge. Once all are met, the FIFO drains with one idle clock between words.
- R4: Each word produces exactly 2*DATA_W SCLK edges, each HALF_CYC clocks apart. SCLK rests at the polarity bit level while idle and after the word.
- R5: With phase=0, the first bit is on `mosi` before the first edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With phase=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R6: With LSB first=1, bit 0 of a word is sent first and the first received bit ends up in bit 0. Otherwise the MSB goes first.
- R7: With loopback=1, the receiver takes `mosi` and `miso` is ignored, so each received word equals the sent word.
- R8: Each FIFO holds FIFO_DEPTH words. Status bits are: 0 RX empty, 1 RX full, 2 TX empty, 3 TX full, 4 mode fault (always 0). A write to transmit data while TX is full is dropped. A read of receive data while RX is empty returns 0.
- R9: Writing 1 to control bit 5 (bit 6) empties the TX (RX) FIFO.
- R10: The slave-select register is active low. With manual select=1, `ss_n` follows it at all times. With manual select=0, `ss_n` follows it only while a word is shifting and is all ones otherwise.
- R11: `tx_empty_evt` pulses high for one cycle after a word finishes while the TX FIFO is empty, and only then.
- R12: A word that completes while the RX FIFO is full is discarded, and the stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on receive data) |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SS_W | Active-low slave selects |
| tx_empty_evt | output | 1 | One-cycle transmit-done event |

## Verification
A bench slave model exchanges bytes with the block in all four polarity/phase combinations. Its own captured byte checks the drive edge, and the byte the block receives checks the sample edge, so a swap of the two edges shows up as a shifted pattern. LSB-first runs against the same MSB-first slave must return bit-reversed values in both directions, which separates an order fault from a phase fault. Loopback bursts run with `miso` held high to show that the pin is ignored. A 17-word burst, one extra word into a full receiver and the flush bits exercise the FIFO limits. Slave-select sampling before, during and after a word tells the manual mode from the automatic one.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h60;
  localparam logic [7:0] OFF_STAT = 8'h64;
  localparam logic [7:0] OFF_TXD  = 8'h68;
  localparam logic [7:0] OFF_RXD  = 8'h6C;
  localparam logic [7:0] OFF_SSEL = 8'h70;

  localparam int CB_LOOP   = 0;
  localparam int CB_EN     = 1;
  localparam int CB_MASTER = 2;
  localparam int CB_CPOL   = 3;
  localparam int CB_CPHA   = 4;
  localparam int CB_TXCLR  = 5;
  localparam int CB_RXCLR  = 6;
  localparam int CB_MANUAL = 7;
  localparam int CB_HOLD   = 8;
  localparam int CB_LSB    = 9;
  localparam int CTRL_W    = 10;

  localparam logic [CTRL_W-1:0] CTRL_RST = 10'h100;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb;
  } spim_mode_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_FULL);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= ptr_next(wp_q);
      if (pop_ok)  rp_q <= ptr_next(rp_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr_i) mem_q[wp_q] <= wdata_i;
  end

  // R8: a push into a full FIFO leaves it full, nothing lost or added
  a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i && !clr_i) |=> (cnt_q == CNT_FULL));
  // R9: a flush leaves the FIFO empty
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> empty_o);
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int WORD_W   = 8,
  parameter int HALF_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [WORD_W-1:0]   tx_word_i,
  input  spim_pkg::spim_mode_t mode_i,
  input  logic                miso_i,
  output logic                busy_o,
  output logic                sclk_o,
  output logic                mosi_o,
  output logic                done_o,
  output logic [WORD_W-1:0]   rx_word_o
);
  localparam int EDGES = 2 * WORD_W;
  localparam int EW    = $clog2(EDGES);
  localparam int TW    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [TW-1:0] TMR_LAST  = TW'(HALF_CYC - 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(EDGES - 1);

  spim_pkg::spim_mode_t mode_q;
  logic              busy_q, ph_q;
  logic [TW-1:0]     tmr_q;
  logic [EW-1:0]     edge_q;
  logic [WORD_W-1:0] txsr_q, rxsr_q;
  logic              edge_tick, lead, sample_now, shift_now;

  function automatic logic [WORD_W-1:0] bits_out(input logic [WORD_W-1:0] sr, input logic lsb);
    return lsb ? {1'b0, sr[WORD_W-1:1]} : {sr[WORD_W-2:0], 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] bits_in(input logic [WORD_W-1:0] sr, input logic b,
                                                input logic lsb);
    return lsb ? {b, sr[WORD_W-1:1]} : {sr[WORD_W-2:0], b};
  endfunction

  function automatic logic head_bit(input logic [WORD_W-1:0] sr, input logic lsb);
    return lsb ? sr[0] : sr[WORD_W-1];
  endfunction

  assign edge_tick  = busy_q && (tmr_q == TMR_LAST);
  assign lead       = ~edge_q[0];
  assign sample_now = edge_tick && (lead != mode_q.cpha);
  assign shift_now  = edge_tick && !sample_now && !(lead && (edge_q == '0));
  assign done_o     = edge_tick && (edge_q == EDGE_LAST);
  assign rx_word_o  = sample_now ? bits_in(rxsr_q, miso_i, mode_q.lsb) : rxsr_q;
  assign busy_o     = busy_q;
  assign sclk_o     = busy_q ? (mode_q.cpol ^ ph_q) : mode_i.cpol;
  assign mosi_o     = head_bit(txsr_q, mode_q.lsb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      tmr_q  <= '0;
      edge_q <= '0;
      txsr_q <= '0;
      rxsr_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        mode_q <= mode_i;
        busy_q <= 1'b1;
        ph_q   <= 1'b0;
        tmr_q  <= '0;
        edge_q <= '0;
        txsr_q <= tx_word_i;
        rxsr_q <= '0;
      end
    end else begin
      tmr_q <= edge_tick ? '0 : tmr_q + 1'b1;
      if (edge_tick) begin
        ph_q   <= ~ph_q;
        edge_q <= edge_q + 1'b1;
      end
      if (done_o)     busy_q <= 1'b0;
      if (shift_now)  txsr_q <= bits_out(txsr_q, mode_q.lsb);
      if (sample_now) rxsr_q <= rx_word_o;
    end
  end

  // R4: an even number of toggles brings SCLK back to its rest level
  a_r4_sclk_home: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !ph_q);
  // R3: a word in progress is never cut short or restarted
  a_r3_word_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_o) |=> busy_q);
  // R5: mosi changes only at a shift edge while busy
  a_r5_mosi_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !shift_now) |=> $stable(mosi_o));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int HALF_CYC   = 2,
  parameter int SS_W       = 4,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SS_W-1:0]   ss_n,
  output logic              tx_empty_evt
);
  import spim_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFF_TXD);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(OFF_RXD);
  localparam logic [ADDR_W-1:0] A_SSEL = ADDR_W'(OFF_SSEL);
  localparam logic [CTRL_W-1:0] FLUSH_MASK = CTRL_W'((1 << CB_TXCLR) | (1 << CB_RXCLR));

  logic [CTRL_W-1:0] ctrl_q;
  logic [SS_W-1:0]   ssel_q;
  logic              evt_q;
  logic sel_ctrl, sel_stat, sel_txd, sel_rxd, sel_ssel;
  logic tx_clr, rx_clr, tx_push, rx_pop, word_load;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic busy, word_done, go, miso_eff;
  spim_mode_t mode;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] off);
    return a[ADDR_W-1:2] == off[ADDR_W-1:2];
  endfunction

  assign sel_ctrl = hit(reg_addr, A_CTRL);
  assign sel_stat = hit(reg_addr, A_STAT);
  assign sel_txd  = hit(reg_addr, A_TXD);
  assign sel_rxd  = hit(reg_addr, A_RXD);
  assign sel_ssel = hit(reg_addr, A_SSEL);

  assign tx_clr  = reg_wr && sel_ctrl && reg_wdata[CB_TXCLR];
  assign rx_clr  = reg_wr && sel_ctrl && reg_wdata[CB_RXCLR];
  assign tx_push = reg_wr && sel_txd;
  assign rx_pop  = reg_rd && sel_rxd;

  assign go        = ctrl_q[CB_EN] && ctrl_q[CB_MASTER] && !ctrl_q[CB_HOLD];
  assign word_load = go && !tx_empty && !busy;
  assign mode      = '{cpol: ctrl_q[CB_CPOL], cpha: ctrl_q[CB_CPHA], lsb: ctrl_q[CB_LSB]};
  assign miso_eff  = ctrl_q[CB_LOOP] ? mosi : miso;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ssel_q <= '1;
      evt_q  <= 1'b0;
    end else begin
      if (reg_wr && sel_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0] & ~FLUSH_MASK;
      if (reg_wr && sel_ssel) ssel_q <= reg_wdata[SS_W-1:0];
      evt_q <= word_done && tx_empty;
    end
  end

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr_i(tx_clr), .push_i(tx_push),
    .wdata_i(reg_wdata[DATA_W-1:0]), .pop_i(word_load), .rdata_o(tx_head),
    .empty_o(tx_empty), .full_o(tx_full));

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr_i(rx_clr), .push_i(word_done),
    .wdata_i(rx_word), .pop_i(rx_pop), .rdata_o(rx_head),
    .empty_o(rx_empty), .full_o(rx_full));

  spim_shifter #(.WORD_W(DATA_W), .HALF_CYC(HALF_CYC)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_i(word_load), .tx_word_i(tx_head),
    .mode_i(mode), .miso_i(miso_eff), .busy_o(busy), .sclk_o(sclk),
    .mosi_o(mosi), .done_o(word_done), .rx_word_o(rx_word));

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl)      reg_rdata = 32'(ctrl_q);
    else if (sel_stat) reg_rdata = {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
    else if (sel_rxd)  reg_rdata = rx_empty ? '0 : 32'(rx_head);
    else if (sel_ssel) reg_rdata = 32'(ssel_q);
  end

  assign ss_n         = (ctrl_q[CB_MANUAL] || busy) ? ssel_q : '1;
  assign tx_empty_evt = evt_q;

  // R3: while held, an idle engine stays idle
  a_r3_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_HOLD] && !busy) |=> !busy);
  // R11: the done event is a single-cycle pulse
  a_r11_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_evt |=> !tx_empty_evt);
  // R10: automatic select releases every line when no word is shifting
  a_r10_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CB_MANUAL] && !busy) |-> (ss_n == '1));
  // R8: reading an empty receiver yields zero
  a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel_rxd && rx_empty) |-> (reg_rdata == '0));
endmodule

// File: tb/spim_ctrl_tb.sv
`timescale 1ns/1ps
module spim_ctrl_tb_top;
  localparam int DW = 8, DEPTH = 16, HALF = 2, SSW = 4;
  localparam int WORD_CYC = 2 * DW * HALF + 1;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic sclk, mosi, miso, tx_empty_evt;
  logic [SSW-1:0] ss_n;

  int n_chk = 0, n_bad = 0;
  int edges = 0, evt_cnt = 0, cyc = 0;
  bit finished = 0;

  logic slv_cpol = 0, slv_cpha = 0;
  logic [7:0] slv_sr = 8'hFF, slv_rx = 0;
  int slv_leads = 0;

  spim_ctrl #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .HALF_CYC(HALF), .SS_W(SSW), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .tx_empty_evt(tx_empty_evt));

  always #4 clk = ~clk;
  assign miso = slv_sr[7];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_empty_evt) evt_cnt <= evt_cnt + 1;
  end

  // MSB-first slave model on the SPI pins
  always @(posedge sclk or negedge sclk) begin
    edges = edges + 1;
    if (sclk != slv_cpol) begin
      if (!slv_cpha) slv_rx = {slv_rx[6:0], mosi};
      else begin
        if (slv_leads != 0) slv_sr = {slv_sr[6:0], 1'b1};
        slv_leads = slv_leads + 1;
      end
    end else begin
      if (!slv_cpha) slv_sr = {slv_sr[6:0], 1'b1};
      else slv_rx = {slv_rx[6:0], mosi};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO/REG FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_evt(output int at);
    int start = evt_cnt;
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (evt_cnt != start) begin at = cyc; break; end
    end
    idle(3);
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h60, d); chk("R1 ctrl", d, 32'h100);
    rd(8'h64, d); chk("R1 status", d, 32'h05);
    rd(8'h70, d); chk("R1 ssel", d, 32'hF);
    chk("R1 ss_n", 32'(ss_n), 32'hF);
    chk("R1 sclk", 32'(sclk), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h60, 32'h3FF);
    rd(8'h60, d); chk("R2 ctrl readback flush bits clear", d, 32'h39F);
    wr(8'h61, 32'h107);  // low address bits ignored
    rd(8'h62, d); chk("R2 ctrl via unaligned address", d, 32'h107);
  endtask

  task automatic t_hold_drain;
    logic [31:0] d;
    int c0, at, e0;
    slv_sr = 8'hFF;
    wr(8'h60, 32'h005);  // loop+master, enable clear, hold clear
    wr(8'h68, 32'h99);
    edges = 0; idle(80);
    chk("R3 no edges while disabled", edges, 0);
    wr(8'h60, 32'h107);  // hold set, enabled
    wr(8'h68, 32'h12); wr(8'h68, 32'h34);
    edges = 0; idle(100);
    chk("R3 no edges while held", edges, 0);
    rd(8'h64, d); chk("R3 status while held", d, 32'h01);
    e0 = evt_cnt;
    wr(8'h60, 32'h007); c0 = cyc; edges = 0;
    wait_evt(at); idle(40);
    chk("R4 edge count of three words", edges, 3 * 2 * DW);
    chk("R3 back-to-back drain", 32'((at - c0) <= 3 * WORD_CYC + 3), 1);
    chk("R11 single event for burst", evt_cnt - e0, 1);
    rd(8'h6C, d); chk("R7 loopback word 0", d, 32'h99);
    rd(8'h6C, d); chk("R7 loopback word 1", d, 32'h12);
    rd(8'h6C, d); chk("R7 loopback word 2", d, 32'h34);
  endtask

  task automatic t_mode(input logic pol, input logic pha, input logic lsb,
                        input logic [7:0] txb, input logic [7:0] sb);
    logic [31:0] d, base;
    int at;
    base = 32'h006 | (32'(pol) << 3) | (32'(pha) << 4) | (32'(lsb) << 9);
    wr(8'h60, base | 32'h100);
    idle(2);
    slv_cpol = pol; slv_cpha = pha; slv_sr = sb; slv_rx = 0; slv_leads = 0;
    wr(8'h68, 32'(txb));
    edges = 0;
    wr(8'h60, base);
    wait_evt(at);
    chk(lsb ? "R6 slave captured" : "R5 slave captured", 32'(slv_rx), 32'(lsb ? rev8(txb) : txb));
    rd(8'h6C, d);
    chk(lsb ? "R6 block received" : "R5 block received", d, 32'(lsb ? rev8(sb) : sb));
    chk("R4 edges per word", edges, 2 * DW);
    chk("R4 sclk rests at polarity", 32'(sclk), 32'(pol));
  endtask

  task automatic t_fifo_limits;
    logic [31:0] d;
    int at;
    slv_cpol = 0; slv_cpha = 0; slv_sr = 8'hFF;
    wr(8'h60, 32'h107);
    for (int i = 0; i < DEPTH + 1; i++) wr(8'h68, 32'h40 + i);
    rd(8'h64, d); chk("R8 status TX full", d, 32'h09);
    wr(8'h60, 32'h007);
    wait_evt(at);
    rd(8'h64, d); chk("R8 status RX full", d, 32'h06);
    wr(8'h68, 32'hEE);
    wait_evt(at);
    rd(8'h64, d); chk("R12 still full after overrun", d, 32'h06);
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h6C, d); chk("R12 stored word kept", d, 32'h40 + i);
    end
    rd(8'h64, d); chk("R8 status drained", d, 32'h05);
    rd(8'h6C, d); chk("R8 empty read is zero", d, 0);
  endtask

  task automatic t_flush;
    logic [31:0] d;
    int at;
    wr(8'h60, 32'h107);
    wr(8'h68, 32'h11); wr(8'h68, 32'h22);
    rd(8'h64, d); chk("R9 TX loaded", d, 32'h01);
    wr(8'h60, 32'h127);
    rd(8'h64, d); chk("R9 TX flushed", d, 32'h05);
    wr(8'h68, 32'h33);
    wr(8'h60, 32'h007);
    wait_evt(at);
    rd(8'h64, d); chk("R9 RX loaded", d, 32'h04);
    wr(8'h60, 32'h047);
    rd(8'h64, d); chk("R9 RX flushed", d, 32'h05);
    rd(8'h60, d); chk("R2 RX flush bit not kept", d, 32'h007);
  endtask

  task automatic t_select;
    logic [31:0] d;
    int at;
    wr(8'h60, 32'h107);
    wr(8'h70, 32'hE);
    idle(2); chk("R10 auto idle released", 32'(ss_n), 32'hF);
    wr(8'h68, 32'h5A);
    wr(8'h60, 32'h007);
    idle(10); chk("R10 auto asserted during word", 32'(ss_n), 32'hE);
    wait_evt(at);
    chk("R10 auto released after word", 32'(ss_n), 32'hF);
    rd(8'h6C, d); chk("R7 loopback select run", d, 32'h5A);
    wr(8'h60, 32'h087);
    idle(2); chk("R10 manual follows register", 32'(ss_n), 32'hE);
    wr(8'h70, 32'hF);
    idle(2); chk("R10 manual deselect all", 32'(ss_n), 32'hF);
  endtask

  initial begin
    idle(4); rst_n = 1; idle(2);
    t_reset;
    t_regs;
    t_hold_drain;
    t_mode(0, 0, 0, 8'h3C, 8'hA6);
    t_mode(0, 1, 0, 8'hC5, 8'h1B);
    t_mode(1, 0, 0, 8'h96, 8'h4D);
    t_mode(1, 1, 0, 8'h2E, 8'hD3);
    t_mode(0, 0, 1, 8'h1D, 8'hB4);
    t_mode(1, 1, 1, 8'h83, 8'h67);
    t_fifo_limits;
    t_flush;
    t_select;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("WATCHDOG FAIL all: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule